// File: doc/BRIEF.md
# Aliased Register-Window Address Decoder

This block sits on the slave side of a bus controller and sorts every incoming address into one of three targets: a configuration register window, an address-translation register window, or ordinary memory (BAR) space. Each register window is 4 KiB long. Both windows are positioned by programmable base addresses.

The address space is divided into blocks whose size is set by a programmable period. The two windows appear again inside every block of that size. An address therefore hits a window when its offset inside its block matches the window's offset inside its block. This holds even when the address lies inside a BAR region. Programming the period to all ones turns the repetition off, and only the absolute window addresses then decode to registers.

Each of the three 64-bit settings is written as two 32-bit words through a small register port. A setting changes only when its high word is written, so the decoder never uses a half-written value. The decode result is a one-hot select plus an offset, registered from the incoming address with one cycle of latency.

Top module: `regwin_decoder`

## Requirements
- R1: After reset the settings read back as: configuration base 0x0, translation base 0x1000, period 0x1000000.
- R2: The register map is: configuration base low/high at 0x00/0x04, translation base low/high at 0x08/0x0C, period low/high at 0x10/0x14. `reg_rdata` returns the committed word at `reg_addr` combinationally, and any other offset reads as zero.
- R3: A write to a low word is held in a staging register. It changes neither the readback nor the decoding until the high word of the same setting is written.
- R4: A write to a high word commits the value {high word, staged low word} at that clock edge. Both readback and decoding use the new value from the next cycle on.
- R5: The decode outputs describe the address presented with `in_valid` one clock earlier. When `in_valid` was low, all three selects are low.
- R6: When a decode is valid, exactly one of `out_sel_cfg`, `out_sel_xlat` and `out_sel_mem` is high.
- R7: With a power-of-two period P, an address A selects a window whose base is B when (A mod P) − (B mod P) lies in [0, 4096). This holds at every multiple of P, including addresses inside a BAR region.
- R8: When an address falls in both windows, the configuration window is selected.
- R9: With the period set to all ones there is no repetition: only addresses in [B, B+4096) select a window.
- R10: For a window hit, `out_off` is the byte offset inside the window (0 to 4095). For a memory decode, `out_off` is the full address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register-port write strobe |
| reg_addr | input | 8 | Register-port byte offset |
| reg_wdata | input | 32 | Register-port write word |
| reg_rdata | output | 32 | Register-port read word |
| in_valid | input | 1 | Incoming access valid |
| in_addr | input | 64 | Incoming access address |
| out_sel_cfg | output | 1 | Configuration window selected |
| out_sel_xlat | output | 1 | Translation window selected |
| out_sel_mem | output | 1 | Memory space selected |
| out_off | output | 64 | Window offset, or full address for memory |

## Verification
The decode is tested first with the reset settings. Addresses at the first block, at a higher multiple of the period and just past a window edge separate a correct aliased match from an absolute one and catch off-by-one errors at the window edges. Staging is tested by decoding between a low-word write and a high-word write, which shows whether a half-written base leaks into the decode. Overlapping windows show the priority order. An all-ones period and then a smaller period show that aliasing can be switched off and that the offset mask follows the programmed size.

// File: rtl/regwin_pkg.sv
// Package: shared constants for the aliased register-window decoder.
// Assumes three 64-bit settings, each placed as a low/high word pair 8 bytes apart.
package regwin_pkg;
    localparam int REG_AW  = 8;
    localparam int NUM_SET = 3;

    typedef enum logic [1:0] {
        SET_CFG    = 2'd0,
        SET_XLAT   = 2'd1,
        SET_PERIOD = 2'd2
    } set_e;

    // Byte offset of the low word of setting i
    function automatic logic [REG_AW-1:0] lo_off(input int i);
        return REG_AW'(i * 8);
    endfunction

    // Byte offset of the high word of setting i
    function automatic logic [REG_AW-1:0] hi_off(input int i);
        return REG_AW'(i * 8 + 4);
    endfunction
endpackage

// File: rtl/regwin_regs.sv
// Module: settings file for the decoder. Holds the configuration base, the
// translation base and the period. Low words are staged, and a high-word
// write commits the whole 64-bit value. Reads are combinational.
// Assumes SET_W == 2*WORD_W.
module regwin_regs
    import regwin_pkg::*;
#(
    parameter int          WORD_W  = 32,
    parameter logic [63:0] CFG_RST = 64'h0,
    parameter logic [63:0] XL_RST  = 64'h1000,
    parameter logic [63:0] PER_RST = 64'h100_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic [2*WORD_W-1:0] cfg_base,
    output logic [2*WORD_W-1:0] xlat_base,
    output logic [2*WORD_W-1:0] period
);
    localparam int SET_W = 2 * WORD_W;

    logic [SET_W-1:0]  val   [NUM_SET];
    logic [WORD_W-1:0] stage [NUM_SET];

    for (genvar i = 0; i < NUM_SET; i++) begin : g_set
        localparam logic [SET_W-1:0] RV = (i == 0) ? SET_W'(CFG_RST) :
                                          (i == 1) ? SET_W'(XL_RST)  : SET_W'(PER_RST);
        localparam logic [REG_AW-1:0] LO = lo_off(i);
        localparam logic [REG_AW-1:0] HI = hi_off(i);

        // Stage the low word; commit the full setting on a high-word write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val[i]   <= RV;
                stage[i] <= '0;
            end else if (reg_we && reg_addr == LO) begin
                stage[i] <= reg_wdata;
            end else if (reg_we && reg_addr == HI) begin
                val[i] <= {reg_wdata, stage[i]};
            end
        end

        p_lo_staged_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == LO) |=> $stable(val[i]));
        p_hi_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == HI) |=> val[i][SET_W-1:WORD_W] == $past(reg_wdata));
    end

    // Readback mux over the committed words; unmapped offsets read zero
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_SET; i++) begin
            if (reg_addr == lo_off(i)) reg_rdata = val[i][WORD_W-1:0];
            if (reg_addr == hi_off(i)) reg_rdata = val[i][SET_W-1:WORD_W];
        end
    end

    assign cfg_base  = val[SET_CFG];
    assign xlat_base = val[SET_XLAT];
    assign period    = val[SET_PERIOD];
endmodule

// File: rtl/regwin_match.sv
// Module: compares one address against one window. Both the address and the
// base are reduced by the period mask, and the window hits when the masked
// address is 0 to WIN_SPAN-1 bytes above the masked base.
// Assumes the mask is period-1 for a power-of-two period, or all ones.
module regwin_match #(
    parameter int SET_W    = 64,
    parameter int WIN_LOG2 = 12
) (
    input  logic [SET_W-1:0]    addr,
    input  logic [SET_W-1:0]    base,
    input  logic [SET_W-1:0]    mask,
    output logic                hit,
    output logic [WIN_LOG2-1:0] off
);
    localparam logic [SET_W-1:0] WIN_SPAN = SET_W'(1) << WIN_LOG2;

    logic [SET_W-1:0] a_m, b_m, diff;

    // Offset of the address above the window start inside its block
    always_comb begin
        a_m  = addr & mask;
        b_m  = base & mask;
        diff = a_m - b_m;
        hit  = (a_m >= b_m) && (diff < WIN_SPAN);
        off  = diff[WIN_LOG2-1:0];
    end
endmodule

// File: rtl/regwin_decoder.sv
// Module: top of the aliased register-window decoder. Registers the incoming
// address, matches it against the configuration and translation windows at
// every period multiple (or absolutely when the period is all ones), and
// drives a one-hot select with the in-window offset one cycle later.
// Assumes the period is a power of two or all ones.
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int WIN_LOG2 = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                in_valid,
    input  logic [2*WORD_W-1:0] in_addr,
    output logic                out_sel_cfg,
    output logic                out_sel_xlat,
    output logic                out_sel_mem,
    output logic [2*WORD_W-1:0] out_off
);
    localparam int SET_W = 2 * WORD_W;
    localparam logic [SET_W-1:0] WIN_SPAN = SET_W'(1) << WIN_LOG2;

    logic [SET_W-1:0]    cfg_base, xlat_base, period, mask;
    logic [SET_W-1:0]    addr_q;
    logic                valid_q;
    logic                cfg_hit, xlat_hit;
    logic [WIN_LOG2-1:0] cfg_off, xlat_off;

    regwin_regs #(.WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_base  (cfg_base),
        .xlat_base (xlat_base),
        .period    (period)
    );

    // Capture the access address for the one-cycle decode stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) addr_q <= in_addr;
        end
    end

    // Offset mask: period-1, or the whole address when aliasing is off
    always_comb mask = (&period) ? '1 : (period - SET_W'(1));

    regwin_match #(.SET_W(SET_W), .WIN_LOG2(WIN_LOG2)) u_cfg_match (
        .addr (addr_q), .base (cfg_base), .mask (mask), .hit (cfg_hit), .off (cfg_off)
    );
    regwin_match #(.SET_W(SET_W), .WIN_LOG2(WIN_LOG2)) u_xlat_match (
        .addr (addr_q), .base (xlat_base), .mask (mask), .hit (xlat_hit), .off (xlat_off)
    );

    // Priority select: configuration, then translation, then memory
    always_comb begin
        out_sel_cfg  = valid_q && cfg_hit;
        out_sel_xlat = valid_q && !cfg_hit && xlat_hit;
        out_sel_mem  = valid_q && !cfg_hit && !xlat_hit;
        if (cfg_hit)       out_off = SET_W'(cfg_off);
        else if (xlat_hit) out_off = SET_W'(xlat_off);
        else               out_off = addr_q;
    end

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones({out_sel_cfg, out_sel_xlat, out_sel_mem}) == 1);
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_sel_cfg || out_sel_xlat || out_sel_mem));
    p_off_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel_cfg || out_sel_xlat) |-> out_off < WIN_SPAN);
    p_mem_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sel_mem -> out_off == $past(in_addr)));
endmodule

// File: tb/regwin_decoder_bench.sv
// Directed bench for the aliased register-window decoder.
module regwin_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        out_sel_cfg, out_sel_xlat, out_sel_mem;
    logic [63:0] out_off;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [2:0] S_CFG = 3'b100, S_XL = 3'b010, S_MEM = 3'b001, S_NONE = 3'b000;

    always #10 clk = ~clk;

    regwin_decoder u_regwin_decoder (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .out_sel_cfg(out_sel_cfg), .out_sel_xlat(out_sel_xlat),
        .out_sel_mem(out_sel_mem), .out_off(out_off)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic dec_chk(input string req, input logic [63:0] a,
                           input logic [2:0] sel, input logic [63:0] off);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " sel"}, 64'({out_sel_cfg, out_sel_xlat, out_sel_mem}), 64'(sel));
        chk({req, " off"}, out_off, off);
    endtask

    // R1, R2: reset values and map
    task automatic t_reset();
        rd_chk("R1 cfg lo", 8'h00, 32'h0);
        rd_chk("R1 cfg hi", 8'h04, 32'h0);
        rd_chk("R1 xlat lo", 8'h08, 32'h1000);
        rd_chk("R1 xlat hi", 8'h0C, 32'h0);
        rd_chk("R1 period lo", 8'h10, 32'h0100_0000);
        rd_chk("R1 period hi", 8'h14, 32'h0);
        rd_chk("R2 unmapped 0x18", 8'h18, 32'h0);
        rd_chk("R2 unmapped 0x80", 8'h80, 32'h0);
    endtask

    // R5, R6, R7, R10: aliasing under the reset settings
    task automatic t_default_alias();
        @(negedge clk);
        chk("R5 idle sel", 64'({out_sel_cfg, out_sel_xlat, out_sel_mem}), 64'(S_NONE));
        dec_chk("R7 cfg at 0", 64'h0, S_CFG, 64'h0);
        dec_chk("R7 xlat first block", 64'h1010, S_XL, 64'h10);
        dec_chk("R10 mem above window", 64'h2000, S_MEM, 64'h2000);
        dec_chk("R7 cfg alias block 1", 64'h100_0020, S_CFG, 64'h20);
        dec_chk("R7 xlat alias last byte", 64'h500_1FFF, S_XL, 64'hFFF);
        dec_chk("R10 mem past alias", 64'h500_2000, S_MEM, 64'h500_2000);
        @(negedge clk);
        chk("R5 sel clears", 64'({out_sel_cfg, out_sel_xlat, out_sel_mem}), 64'(S_NONE));
    endtask

    // R3, R4: staged low word, commit on high word
    task automatic t_staging();
        wr(8'h00, 32'h3000);
        rd_chk("R3 lo not visible", 8'h00, 32'h0);
        dec_chk("R3 old base decode", 64'h10, S_CFG, 64'h10);
        dec_chk("R3 new base unused", 64'h3010, S_MEM, 64'h3010);
        wr(8'h04, 32'h0);
        rd_chk("R4 lo committed", 8'h00, 32'h3000);
        dec_chk("R4 new base decode", 64'h3010, S_CFG, 64'h10);
        dec_chk("R4 old base gone", 64'h10, S_MEM, 64'h10);
    endtask

    // R8: overlapping windows
    task automatic t_priority();
        wr(8'h08, 32'h3800);
        wr(8'h0C, 32'h0);
        dec_chk("R8 overlap cfg wins", 64'h3900, S_CFG, 64'h900);
        dec_chk("R8 xlat tail", 64'h4100, S_XL, 64'h900);
        dec_chk("R7 xlat tail alias", 64'h2_0100_4100, S_XL, 64'h900);
    endtask

    // R9, R4: all-ones period disables aliasing; smaller period re-enables
    task automatic t_disable();
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R4 period hi", 8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'h2000_0000);
        wr(8'h04, 32'h1);
        rd_chk("R4 cfg hi", 8'h04, 32'h1);
        dec_chk("R9 absolute cfg", 64'h1_2000_0040, S_CFG, 64'h40);
        dec_chk("R9 low alias gone", 64'h40, S_MEM, 64'h40);
        dec_chk("R9 absolute xlat", 64'h3800, S_XL, 64'h0);
        dec_chk("R9 block alias gone", 64'h100_3800, S_MEM, 64'h100_3800);
        wr(8'h10, 32'h0001_0000);
        wr(8'h14, 32'h0);
        dec_chk("R7 small period xlat", 64'h7_0003_3810, S_XL, 64'h10);
        dec_chk("R7 small period cfg", 64'h7_0005_0FFF, S_CFG, 64'hFFF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default_alias();
        t_staging();
        t_priority();
        t_disable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule